// File: doc/BRIEF.md
# Super-Block Tag Hit Detector

This block is the lookup path for one set of a compressed last-level cache in which each address tag covers a super block. A super block is four neighbouring 64-byte lines, aligned so that the first line's block number is a multiple of four. The data storage of the set is cut into 16-byte segments, and any segment may hold part of any line of any super block in the set. Each segment carries its own back pointer. The back pointer names the tag slot (way) the segment belongs to and which of the four lines it stores.

A lookup takes a byte address. The block splits the address into line-in-super-block offset, set index and super-block tag, and compares the tag against all four tag slots at once. It also compares every segment's back pointer against the requested line offset. One clock later it reports whether the line is present. On a hit it gives the way that matched and a one-hot-per-segment mask of the segments holding the line. On a miss it tells a block miss (the super block is present but the line is not) from a super-block miss (no tag matched). It also returns the coherence state and compression type that the matching tag keeps for the requested line.

Tag slots and back pointers are held in registers for one set and are loaded through two simple write ports. Reading segment data, decompression, victim choice and coherence actions belong to other blocks.

Top module: `sbtag_hit_detector`

## Requirements
- R1: The request address is split as follows: bits [5:0] are the byte within a line, bits [7:6] the line offset inside the super block, bits [13:8] the set index, and bits [31:14] the super-block tag. res_boff and res_set report the offset and set index of the request.
- R2: res_valid is high exactly in the cycle after a cycle with req_valid high. Whenever res_valid is low, res_hit, res_miss, res_way, res_seg_mask, res_set, res_boff, res_coh and res_ctype are all zero.
- R3: A tag slot matches only when its valid bit is set and its stored tag equals the request tag. When several slots match, the lowest-numbered way is the matching way and is reported in res_way.
- R4: A hit (res_hit=1, res_miss=0) needs three things together: a matching way, a valid segment whose stored offset equals the request offset, and that segment's stored way index equal to the matching way.
- R5: On a hit, bit i of res_seg_mask is 1 exactly when segment i is valid, stores the requested offset and points at the matching way. Bits of segments that fail any of these are 0.
- R6: When a way matches but no segment meets R4, the result is a block miss. res_miss=1, res_hit=0, res_seg_mask=0, and res_way gives the matching way.
- R7: When no way matches, the result is a super-block miss whatever the segments hold. res_miss=2, res_hit=0, res_seg_mask=0, res_way=0, res_coh=0 and res_ctype=0.
- R8: Each tag slot keeps a 2-bit coherence state and a 2-bit compression type for each of its four lines. The field for line b sits at bits [2b+1:2b] of tag_coh and tag_ctype. On a hit or a block miss, res_coh and res_ctype give the requested line's fields from the matching way.
- R9: Reset clears every tag and segment valid bit, so a lookup after reset is a super-block miss. A tag or segment write takes effect at the clock edge. A lookup in the same cycle as a write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Byte address of the lookup |
| tag_we | input | 1 | Tag slot write enable |
| tag_way | input | 2 | Tag slot to write |
| tag_valid | input | 1 | Valid bit written to the slot |
| tag_value | input | 18 | Super-block tag written to the slot |
| tag_coh | input | 8 | Per-line coherence states, line b at [2b+1:2b] |
| tag_ctype | input | 8 | Per-line compression types, line b at [2b+1:2b] |
| seg_we | input | 1 | Segment back-pointer write enable |
| seg_idx | input | 4 | Segment to write |
| seg_valid | input | 1 | Segment valid bit |
| seg_tidx | input | 2 | Way index stored in the back pointer |
| seg_boff | input | 2 | Line offset stored in the back pointer |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_hit | output | 1 | Line present |
| res_miss | output | 2 | 0 none, 1 block miss, 2 super-block miss |
| res_way | output | 2 | Matching way |
| res_seg_mask | output | 16 | Segments holding the requested line |
| res_set | output | 6 | Set index of the request |
| res_boff | output | 2 | Line offset of the request |
| res_coh | output | 2 | Coherence state of the requested line |
| res_ctype | output | 2 | Compression type of the requested line |

## Verification
Every result field is registered, so all of them are due on the first rising edge after the request edge, and they drop to zero one edge after the request goes away. The bench drives inputs on the falling edge. It computes the expected result from its own model of the set before applying the same cycle's writes to that model. It then compares all fields at the next falling edge, after the single rising edge has passed. Directed cases cover lookups that coincide with writes, duplicate tags, back pointers aimed at the wrong way, and invalidated slots. Random traffic over a small tag pool then keeps hits, block misses and super-block misses all frequent.

// File: rtl/sbtag_pkg.sv
package sbtag_pkg;

  localparam int unsigned MISS_W = 2;
  localparam logic [MISS_W-1:0] MISS_NONE  = 2'd0;
  localparam logic [MISS_W-1:0] MISS_BLOCK = 2'd1;
  localparam logic [MISS_W-1:0] MISS_SUPER = 2'd2;

  // Extract a w-bit field starting at bit lo of an address.
  function automatic logic [63:0] addr_field(input logic [63:0] addr,
                                             input int unsigned lo,
                                             input int unsigned w);
    logic [63:0] m;
    m = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (addr >> lo) & m;
  endfunction

  // Index of the lowest set bit among the first n bits, 0 if none.
  function automatic int unsigned lowest_set(input logic [63:0] v,
                                             input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = int'(n) - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Bit position of the per-line field for (way, line) in a flattened table.
  function automatic int unsigned slot_base(input int unsigned way,
                                            input int unsigned line,
                                            input int unsigned lines,
                                            input int unsigned w);
    return (way * lines + line) * w;
  endfunction

endpackage

// File: rtl/sbtag_tag_store.sv
module sbtag_tag_store #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned TAG_W  = 18,
  parameter int unsigned INFO_W = 8,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WAY_W-1:0]         wr_way,
  input  logic                     wr_valid,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [INFO_W-1:0]        wr_coh,
  input  logic [INFO_W-1:0]        wr_ct,
  input  logic [TAG_W-1:0]         req_tag,
  output logic [WAYS-1:0]          tag_match,
  output logic [WAYS*INFO_W-1:0]   coh_flat,
  output logic [WAYS*INFO_W-1:0]   ct_flat
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [INFO_W-1:0] coh_q;
    logic [INFO_W-1:0] ct_q;
    logic              sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        coh_q <= '0;
        ct_q  <= '0;
      end else if (sel) begin
        vld_q <= wr_valid;
        tag_q <= wr_tag;
        coh_q <= wr_coh;
        ct_q  <= wr_ct;
      end
    end

    assign tag_match[w] = vld_q && (tag_q == req_tag);
    assign coh_flat[w*INFO_W +: INFO_W] = coh_q;
    assign ct_flat[w*INFO_W +: INFO_W]  = ct_q;
  end

endmodule

// File: rtl/sbtag_seg_store.sv
module sbtag_seg_store #(
  parameter int unsigned SEGS   = 16,
  parameter int unsigned WAY_W  = 2,
  parameter int unsigned BOFF_W = 2,
  localparam int unsigned SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEG_W-1:0]        wr_idx,
  input  logic                    wr_valid,
  input  logic [WAY_W-1:0]        wr_tidx,
  input  logic [BOFF_W-1:0]       wr_boff,
  input  logic [BOFF_W-1:0]       req_boff,
  output logic [SEGS-1:0]         seg_valid,
  output logic [SEGS-1:0]         seg_off_hit,
  output logic [SEGS*WAY_W-1:0]   seg_tidx_flat
);

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic              vld_q;
    logic [WAY_W-1:0]  tidx_q;
    logic [BOFF_W-1:0] boff_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == SEG_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        tidx_q <= '0;
        boff_q <= '0;
      end else if (sel) begin
        vld_q  <= wr_valid;
        tidx_q <= wr_tidx;
        boff_q <= wr_boff;
      end
    end

    assign seg_valid[s]                        = vld_q;
    assign seg_off_hit[s]                      = vld_q && (boff_q == req_boff);
    assign seg_tidx_flat[s*WAY_W +: WAY_W]     = tidx_q;
  end

endmodule

// File: rtl/sbtag_resolve.sv
module sbtag_resolve
  import sbtag_pkg::*;
#(
  parameter int unsigned WAYS    = 4,
  parameter int unsigned SEGS    = 16,
  parameter int unsigned SB_BLKS = 4,
  parameter int unsigned COH_W   = 2,
  parameter int unsigned CT_W    = 2,
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned BOFF_W = (SB_BLKS > 1) ? $clog2(SB_BLKS) : 1
) (
  input  logic [WAYS-1:0]                  tag_match,
  input  logic [SEGS-1:0]                  seg_off_hit,
  input  logic [SEGS*WAY_W-1:0]            seg_tidx_flat,
  input  logic [WAYS*SB_BLKS*COH_W-1:0]    coh_flat,
  input  logic [WAYS*SB_BLKS*CT_W-1:0]     ct_flat,
  input  logic [BOFF_W-1:0]                req_boff,
  output logic                             any_tag,
  output logic                             hit,
  output logic [MISS_W-1:0]                miss,
  output logic [WAY_W-1:0]                 way,
  output logic [SEGS-1:0]                  seg_mask,
  output logic [COH_W-1:0]                 coh,
  output logic [CT_W-1:0]                  ct
);

  logic [WAY_W-1:0] way_i;

  assign any_tag = |tag_match;
  assign way_i   = WAY_W'(lowest_set(64'(tag_match), WAYS));

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    assign seg_mask[s] = any_tag && seg_off_hit[s]
                         && (seg_tidx_flat[s*WAY_W +: WAY_W] == way_i);
  end

  assign hit = |seg_mask;

  always_comb begin
    int unsigned cb;
    int unsigned kb;
    cb = slot_base(int'(way_i), int'(req_boff), SB_BLKS, COH_W);
    kb = slot_base(int'(way_i), int'(req_boff), SB_BLKS, CT_W);
    if (!any_tag) begin
      miss = MISS_SUPER;
      way  = '0;
      coh  = '0;
      ct   = '0;
    end else begin
      miss = hit ? MISS_NONE : MISS_BLOCK;
      way  = way_i;
      coh  = coh_flat[cb +: COH_W];
      ct   = ct_flat[kb +: CT_W];
    end
  end

endmodule

// File: rtl/sbtag_hit_detector.sv
module sbtag_hit_detector
  import sbtag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned SB_BLKS    = 4,
  parameter int unsigned SET_W      = 6,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned SEGS       = 16,
  parameter int unsigned COH_W      = 2,
  parameter int unsigned CT_W       = 2,
  localparam int unsigned LINE_W    = $clog2(LINE_BYTES),
  localparam int unsigned BOFF_W    = (SB_BLKS > 1) ? $clog2(SB_BLKS) : 1,
  localparam int unsigned TAG_W     = ADDR_W - LINE_W - BOFF_W - SET_W,
  localparam int unsigned WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SEG_W     = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     tag_we,
  input  logic [WAY_W-1:0]         tag_way,
  input  logic                     tag_valid,
  input  logic [TAG_W-1:0]         tag_value,
  input  logic [SB_BLKS*COH_W-1:0] tag_coh,
  input  logic [SB_BLKS*CT_W-1:0]  tag_ctype,
  input  logic                     seg_we,
  input  logic [SEG_W-1:0]         seg_idx,
  input  logic                     seg_valid,
  input  logic [WAY_W-1:0]         seg_tidx,
  input  logic [BOFF_W-1:0]        seg_boff,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic [MISS_W-1:0]        res_miss,
  output logic [WAY_W-1:0]         res_way,
  output logic [SEGS-1:0]          res_seg_mask,
  output logic [SET_W-1:0]         res_set,
  output logic [BOFF_W-1:0]        res_boff,
  output logic [COH_W-1:0]         res_coh,
  output logic [CT_W-1:0]          res_ctype
);

  // Address split
  logic [BOFF_W-1:0] req_boff;
  logic [SET_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;

  assign req_boff = BOFF_W'(addr_field(64'(req_addr), LINE_W, BOFF_W));
  assign req_set  = SET_W'(addr_field(64'(req_addr), LINE_W + BOFF_W, SET_W));
  assign req_tag  = TAG_W'(addr_field(64'(req_addr), LINE_W + BOFF_W + SET_W, TAG_W));

  // Named internal events, also observed by the checker
  logic [WAYS-1:0]                tag_match;
  logic [SEGS-1:0]                seg_valid_vec;
  logic [SEGS-1:0]                seg_off_hit;
  logic [SEGS*WAY_W-1:0]          seg_tidx_flat;
  logic [WAYS*SB_BLKS*COH_W-1:0]  coh_flat;
  logic [WAYS*SB_BLKS*CT_W-1:0]   ct_flat;
  logic                           any_tag;
  logic                           hit_now;
  logic [MISS_W-1:0]              miss_now;
  logic [WAY_W-1:0]               way_now;
  logic [SEGS-1:0]                mask_now;
  logic [COH_W-1:0]               coh_now;
  logic [CT_W-1:0]                ct_now;

  sbtag_tag_store #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .INFO_W(SB_BLKS * COH_W)
  ) tags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tag_we),
    .wr_way   (tag_way),
    .wr_valid (tag_valid),
    .wr_tag   (tag_value),
    .wr_coh   (tag_coh),
    .wr_ct    (tag_ctype),
    .req_tag  (req_tag),
    .tag_match(tag_match),
    .coh_flat (coh_flat),
    .ct_flat  (ct_flat)
  );

  sbtag_seg_store #(
    .SEGS  (SEGS),
    .WAY_W (WAY_W),
    .BOFF_W(BOFF_W)
  ) segs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (seg_we),
    .wr_idx       (seg_idx),
    .wr_valid     (seg_valid),
    .wr_tidx      (seg_tidx),
    .wr_boff      (seg_boff),
    .req_boff     (req_boff),
    .seg_valid    (seg_valid_vec),
    .seg_off_hit  (seg_off_hit),
    .seg_tidx_flat(seg_tidx_flat)
  );

  sbtag_resolve #(
    .WAYS   (WAYS),
    .SEGS   (SEGS),
    .SB_BLKS(SB_BLKS),
    .COH_W  (COH_W),
    .CT_W   (CT_W)
  ) resolve_i (
    .tag_match    (tag_match),
    .seg_off_hit  (seg_off_hit),
    .seg_tidx_flat(seg_tidx_flat),
    .coh_flat     (coh_flat),
    .ct_flat      (ct_flat),
    .req_boff     (req_boff),
    .any_tag      (any_tag),
    .hit          (hit_now),
    .miss         (miss_now),
    .way          (way_now),
    .seg_mask     (mask_now),
    .coh          (coh_now),
    .ct           (ct_now)
  );

  // Result register: one cycle of latency, cleared when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_miss     <= MISS_NONE;
      res_way      <= '0;
      res_seg_mask <= '0;
      res_set      <= '0;
      res_boff     <= '0;
      res_coh      <= '0;
      res_ctype    <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_hit      <= hit_now;
        res_miss     <= miss_now;
        res_way      <= way_now;
        res_seg_mask <= mask_now;
        res_set      <= req_set;
        res_boff     <= req_boff;
        res_coh      <= coh_now;
        res_ctype    <= ct_now;
      end else begin
        res_hit      <= 1'b0;
        res_miss     <= MISS_NONE;
        res_way      <= '0;
        res_seg_mask <= '0;
        res_set      <= '0;
        res_boff     <= '0;
        res_coh      <= '0;
        res_ctype    <= '0;
      end
    end
  end

endmodule

// File: rtl/sbtag_hit_detector_chk.sv
module sbtag_hit_detector_chk
  import sbtag_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SEGS  = 16,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned COH_W = 2,
  parameter int unsigned CT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [WAYS-1:0]   tag_match,
  input logic [SEGS-1:0]   seg_valid_vec,
  input logic              res_valid,
  input logic              res_hit,
  input logic [MISS_W-1:0] res_miss,
  input logic [WAY_W-1:0]  res_way,
  input logic [SEGS-1:0]   res_seg_mask,
  input logic [COH_W-1:0]  res_coh,
  input logic [CT_W-1:0]   res_ctype
);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !res_hit && res_miss == MISS_NONE
                    && res_seg_mask == '0 && res_way == '0));

  assert_hit_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_valid && res_miss == MISS_NONE && res_seg_mask != '0));

  assert_mask_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_seg_mask & ~$past(seg_valid_vec)) == '0));

  assert_miss_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_seg_mask == '0 && res_miss != MISS_NONE));

  assert_tag_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tag_match != '0) |=> (res_miss != MISS_SUPER));

  assert_super_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tag_match == '0) |=> (res_miss == MISS_SUPER && !res_hit
                                        && res_way == '0 && res_coh == '0
                                        && res_ctype == '0));

endmodule

bind sbtag_hit_detector sbtag_hit_detector_chk #(
  .WAYS (WAYS),
  .SEGS (SEGS),
  .WAY_W(WAY_W),
  .COH_W(COH_W),
  .CT_W (CT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .tag_match    (tag_match),
  .seg_valid_vec(seg_valid_vec),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_miss     (res_miss),
  .res_way      (res_way),
  .res_seg_mask (res_seg_mask),
  .res_coh      (res_coh),
  .res_ctype    (res_ctype)
);

// File: tb/sbtag_hit_detector_tb_top.sv
`timescale 1ns/100ps
module sbtag_hit_detector_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        tag_we = 1'b0;
  logic [1:0]  tag_way = '0;
  logic        tag_valid = 1'b0;
  logic [17:0] tag_value = '0;
  logic [7:0]  tag_coh = '0;
  logic [7:0]  tag_ctype = '0;
  logic        seg_we = 1'b0;
  logic [3:0]  seg_idx = '0;
  logic        seg_valid = 1'b0;
  logic [1:0]  seg_tidx = '0;
  logic [1:0]  seg_boff = '0;

  logic        res_valid;
  logic        res_hit;
  logic [1:0]  res_miss;
  logic [1:0]  res_way;
  logic [15:0] res_seg_mask;
  logic [5:0]  res_set;
  logic [1:0]  res_boff;
  logic [1:0]  res_coh;
  logic [1:0]  res_ctype;

  always #2.5 clk = ~clk;

  sbtag_hit_detector dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .tag_we(tag_we), .tag_way(tag_way), .tag_valid(tag_valid),
    .tag_value(tag_value), .tag_coh(tag_coh), .tag_ctype(tag_ctype),
    .seg_we(seg_we), .seg_idx(seg_idx), .seg_valid(seg_valid),
    .seg_tidx(seg_tidx), .seg_boff(seg_boff),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_way(res_way), .res_seg_mask(res_seg_mask), .res_set(res_set),
    .res_boff(res_boff), .res_coh(res_coh), .res_ctype(res_ctype)
  );

  // Bench model of the set
  logic        m_tv  [4];
  logic [17:0] m_tag [4];
  logic [7:0]  m_coh [4];
  logic [7:0]  m_ct  [4];
  logic        m_sv  [16];
  logic [1:0]  m_st  [16];
  logic [1:0]  m_sb  [16];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] mk_addr(logic [17:0] t, logic [5:0] s, logic [1:0] b, logic [5:0] lo);
    return {t, s, b, lo};
  endfunction

  // One clock: predict from the model, clock the DUT, update model, compare.
  task automatic tick(string lbl);
    logic        e_v, e_hit;
    logic [1:0]  e_miss, e_way, e_boff, e_coh, e_ct;
    logic [15:0] e_mask;
    logic [5:0]  e_set;
    logic [17:0] t;
    bit          found;
    int          bo;
    e_v = req_valid; e_hit = 0; e_miss = 0; e_way = 0; e_mask = 0;
    e_set = 0; e_boff = 0; e_coh = 0; e_ct = 0;
    if (req_valid) begin
      e_boff = req_addr[7:6];
      e_set  = req_addr[13:8];
      t      = req_addr[31:14];
      bo     = int'(e_boff);
      found  = 0;
      for (int w = 0; w < 4; w++)
        if (!found && m_tv[w] && m_tag[w] == t) begin found = 1; e_way = 2'(w); end
      if (found) begin
        for (int s = 0; s < 16; s++)
          e_mask[s] = m_sv[s] && m_sb[s] == e_boff && m_st[s] == e_way;
        e_hit  = (e_mask != 0);
        e_miss = e_hit ? 2'd0 : 2'd1;
        e_coh  = m_coh[e_way][2*bo +: 2];
        e_ct   = m_ct[e_way][2*bo +: 2];
      end else begin
        e_miss = 2'd2;
      end
    end
    @(posedge clk);
    if (tag_we) begin
      m_tv[tag_way] = tag_valid; m_tag[tag_way] = tag_value;
      m_coh[tag_way] = tag_coh; m_ct[tag_way] = tag_ctype;
    end
    if (seg_we) begin
      m_sv[seg_idx] = seg_valid; m_st[seg_idx] = seg_tidx; m_sb[seg_idx] = seg_boff;
    end
    @(negedge clk);
    chk({lbl, " R2"}, "res_valid", 32'(res_valid), 32'(e_v));
    chk({lbl, " R1"}, "res_set",   32'(res_set),   32'(e_set));
    chk({lbl, " R1"}, "res_boff",  32'(res_boff),  32'(e_boff));
    chk({lbl, " R4"}, "res_hit",   32'(res_hit),   32'(e_hit));
    chk({lbl, " R6/R7"}, "res_miss", 32'(res_miss), 32'(e_miss));
    chk({lbl, " R3"}, "res_way",   32'(res_way),   32'(e_way));
    chk({lbl, " R5"}, "res_seg_mask", 32'(res_seg_mask), 32'(e_mask));
    chk({lbl, " R8"}, "res_coh",   32'(res_coh),   32'(e_coh));
    chk({lbl, " R8"}, "res_ctype", 32'(res_ctype), 32'(e_ct));
    req_valid = 0; tag_we = 0; seg_we = 0;
  endtask

  task automatic look(logic [17:0] t, logic [1:0] b, string lbl);
    req_valid = 1;
    req_addr  = mk_addr(t, 6'($urandom), b, 6'($urandom));
    tick(lbl);
  endtask

  task automatic set_tag(logic [1:0] w, logic v, logic [17:0] t, logic [7:0] c, logic [7:0] k);
    tag_we = 1; tag_way = w; tag_valid = v; tag_value = t; tag_coh = c; tag_ctype = k;
  endtask

  task automatic set_seg(logic [3:0] i, logic v, logic [1:0] ti, logic [1:0] b);
    seg_we = 1; seg_idx = i; seg_valid = v; seg_tidx = ti; seg_boff = b;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2: act=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EB1_0C4D));
    for (int w = 0; w < 4; w++) begin m_tv[w] = 0; m_tag[w] = 0; m_coh[w] = 0; m_ct[w] = 0; end
    for (int s = 0; s < 16; s++) begin m_sv[s] = 0; m_st[s] = 0; m_sb[s] = 0; end
    repeat (3) @(negedge clk);
    // R2: reset state of the result fields
    chk("reset R2", "res_valid", 32'(res_valid), 32'd0);
    chk("reset R2", "res_seg_mask", 32'(res_seg_mask), 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R9: everything invalid after reset -> super-block miss
    look(18'h00000, 2'd0, "after reset R9");
    // R9: write and lookup in the same cycle sees old contents
    set_tag(2'd1, 1'b1, 18'h00155, 8'b11_10_01_00, 8'b00_01_10_11);
    look(18'h00155, 2'd2, "same-cycle write R9");
    // R6/R8: tag present, no segments -> block miss with per-line state
    look(18'h00155, 2'd2, "no segments R6 R8");
    set_seg(4'd3,  1'b1, 2'd1, 2'd2); tick("seg wr R9");
    set_seg(4'd9,  1'b1, 2'd1, 2'd2); tick("seg wr R9");
    set_seg(4'd5,  1'b1, 2'd0, 2'd2); tick("seg wr R9");
    set_seg(4'd12, 1'b1, 2'd1, 2'd1); tick("seg wr R9");
    // R5: two segments hold the line; seg 5 points at another way
    look(18'h00155, 2'd2, "multi-seg hit R5");
    look(18'h00155, 2'd1, "single-seg hit R4");
    look(18'h00155, 2'd0, "offset absent R6");
    // R3/R4: duplicate tag in way 2; segment for way 2 only -> lowest way wins, block miss
    set_tag(2'd2, 1'b1, 18'h00155, 8'hA5, 8'h5A); tick("tag wr R9");
    set_seg(4'd7, 1'b1, 2'd2, 2'd3); tick("seg wr R9");
    look(18'h00155, 2'd3, "wrong way R3 R4");
    // R3: invalid slot never matches even with equal tag value
    set_tag(2'd1, 1'b0, 18'h00155, 8'hFF, 8'hFF); tick("tag inval R3");
    look(18'h00155, 2'd3, "invalid slot R3");
    // R7: no tag match while segments match the offset
    look(18'h002AA, 2'd2, "super miss R7");
    // R9: segment invalidated -> no longer in the mask
    set_seg(4'd7, 1'b0, 2'd2, 2'd3); tick("seg inval R9");
    look(18'h00155, 2'd3, "seg invalid R5");
    // Random traffic over a small tag pool
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 70) begin
        req_valid = 1;
        req_addr  = mk_addr(18'($urandom_range(5)), 6'($urandom), 2'($urandom), 6'($urandom));
      end
      if ($urandom_range(99) < 10)
        set_tag(2'($urandom), ($urandom_range(9) != 0), 18'($urandom_range(5)),
                8'($urandom), 8'($urandom));
      if ($urandom_range(99) < 30)
        set_seg(4'($urandom), ($urandom_range(7) != 0), 2'($urandom), 2'($urandom));
      tick("random R4 R5");
    end
    done = 1;
    finish_run();
  end

endmodule